// File: doc/BRIEF.md
# MAC-PHY Interrupt and Status Generator

This block sits on the device side of a serial MAC-PHY link and drives an active-low interrupt line towards the host. The line is pulled low when one of three things becomes available after the last data footer reported that it was absent: receive chunks, transmit credits, or an extended status event. A pending availability condition is dropped when the host starts its next data transfer, which is marked by the first data header strobe. The line does not follow a level.

A sticky status register records four error events and a reset-complete event. The host clears any bit by writing a one to it. Each error source has a mask bit, and all four masks are set after reset. The extended-status flag placed in the footer is the OR of the unmasked error bits and the reset-complete bit. While reset-complete stays set, the interrupt line stays low whatever headers arrive.

Each availability source runs its own three-state machine. The states are `AV_IDLE`, where the last footer showed the item present, `AV_ARMED`, where the last footer showed it absent, and `AV_PEND`, where the interrupt is pending. The transitions are:
- IDLE to ARMED on a footer that reports zero.
- ARMED to IDLE on a footer that reports non-zero.
- ARMED to PEND when the item becomes available and no footer arrives in that cycle.
- PEND to IDLE on a header. If a footer reporting zero arrives in the same cycle as that header, the move is PEND to ARMED.
- Reset enters ARMED.

Top module: `mphy_irq_gen`

## Requirements
- R1: After reset, irq_n is 1, status is 0 and exst is 0.
- R2: When the last footer reported zero receive chunks, a non-zero rx_chunks count drives irq_n low two cycles later. When the last footer reported a non-zero count, a later rise of rx_chunks does not assert the interrupt.
- R3: The same rule as R2 applies to tx_credits against the footer's credit count.
- R4: A hdr_strb pulse clears every pending availability condition. When nothing else holds the line, irq_n returns to 1 two cycles after the header, and the same availability does not re-fire before the next footer.
- R5: Status bits are sticky. One cycle after an error strobe, its bit is set whatever its mask. The positions are: bit0 transmit protocol error, bit1 receive buffer overflow, bit2 loss of framing, bit3 header error, bit4 reset complete.
- R6: exst equals the OR of status[3:0] AND NOT mask, ORed with status[4]. A mask bit of 1 masks its error. A mask write takes effect one cycle after mask_we.
- R7: When the last footer carried exst=0, a rise of exst drives irq_n low two cycles after the rise, which is three cycles after the error strobe.
- R8: A reset_done pulse sets status[4] one cycle later and pulls irq_n low one cycle after that. irq_n stays low through headers until status[4] is cleared, and it returns to 1 two cycles after the clearing write.
- R9: A clr_we write clears each status bit where clr_data holds 1 and leaves the other bits alone. An event strobe in the same cycle as its clear wins, and the bit stays set.
- R10: A masked error changes neither exst nor irq_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_chunks | input | CNT_W | Current receive chunks available |
| tx_credits | input | CNT_W | Current free transmit credits |
| err_strb | input | 4 | Error event strobes, same bit order as status[3:0] |
| rst_done | input | 1 | Reset-complete strobe |
| ftr_valid | input | 1 | A footer is being reported this cycle |
| ftr_rx_cnt | input | CNT_W | Receive-chunk count carried by that footer |
| ftr_tx_cnt | input | CNT_W | Credit count carried by that footer |
| hdr_strb | input | 1 | First data header of a transfer received |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 4 | New mask value, 1 = masked |
| clr_we | input | 1 | Status write-one-to-clear enable |
| clr_data | input | 5 | Bits to clear |
| irq_n | output | 1 | Registered active-low interrupt |
| status | output | 5 | Sticky status register |
| exst | output | 1 | Extended-status flag for the footer |

## Verification
Status and exst follow a strobe or write by one cycle. An availability interrupt reaches irq_n two cycles after the count rises, through the state register and the output flop. An error-driven interrupt needs three cycles, because the status register comes first. The release after a header takes two cycles. Every stimulus pushes its expected tuple into a queue, stamped with the exact cycle in which it is due. The monitor compares that tuple at the falling edge of that cycle. The intermediate cycles are also pushed, so a result that arrives one cycle early or late is caught.

// File: rtl/mphy_irq_pkg.sv
package mphy_irq_pkg;
    localparam int NERR   = 4;
    localparam int STS_W  = NERR + 1;
    localparam int RSTC_B = NERR;
    localparam int NSRC   = 3;   // receive, credit, extended status

    typedef enum logic [1:0] {
        AV_IDLE  = 2'd0,
        AV_ARMED = 2'd1,
        AV_PEND  = 2'd2
    } av_state_e;
endpackage

// File: rtl/mphy_avail_fsm.sv
module mphy_avail_fsm
    import mphy_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic avail,
    input  logic ftr_valid,
    input  logic ftr_zero,
    input  logic hdr_strb,
    output logic pend
);
    av_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= AV_ARMED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            AV_IDLE: begin
                if (ftr_valid && ftr_zero) st_d = AV_ARMED;
            end
            AV_ARMED: begin
                if (ftr_valid)  st_d = ftr_zero ? AV_ARMED : AV_IDLE;
                else if (avail) st_d = AV_PEND;
            end
            AV_PEND: begin
                if (hdr_strb) st_d = (ftr_valid && ftr_zero) ? AV_ARMED : AV_IDLE;
            end
            default: st_d = AV_ARMED;
        endcase
    end

    always_comb begin
        pend = (st_q == AV_PEND);
    end

    // R2 R3 R7: armed source fires once the item shows up
    a_r2_armed_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == AV_ARMED && !ftr_valid && avail) |=> pend);
    // R4: header drops the pending condition
    a_r4_hdr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && hdr_strb) |=> !pend);
    // R2: pending can only follow an armed state
    a_r2_pend_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(st_q) == AV_ARMED);
endmodule

// File: rtl/mphy_sts_reg.sv
module mphy_sts_reg
    import mphy_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NERR-1:0]  err_strb,
    input  logic             rst_done,
    input  logic             mask_we,
    input  logic [NERR-1:0]  mask_wdata,
    input  logic             clr_we,
    input  logic [STS_W-1:0] clr_data,
    output logic [STS_W-1:0] sts,
    output logic             exst
);
    logic [STS_W-1:0] set_v;
    logic [STS_W-1:0] sts_q;
    logic [NERR-1:0]  mask_q;

    assign set_v = {rst_done, err_strb};

    generate
        for (genvar i = 0; i < STS_W; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        sts_q[i] <= 1'b0;
                else if (set_v[i]) sts_q[i] <= 1'b1;
                else if (clr_we && clr_data[i]) sts_q[i] <= 1'b0;
            end

            // R5 R8: a bit survives until a clearing write hits it
            a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (sts_q[i] && !(clr_we && clr_data[i])) |=> sts_q[i]);
            // R9: event beats clear in the same cycle
            a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                set_v[i] |=> sts_q[i]);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_we) mask_q <= mask_wdata;
    end

    assign sts  = sts_q;
    assign exst = (|(sts_q[NERR-1:0] & ~mask_q)) | sts_q[RSTC_B];

    // R10: with every error masked and no reset-complete, the flag is low
    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1 && !sts_q[RSTC_B]) |-> !exst);
endmodule

// File: rtl/mphy_irq_gen.sv
module mphy_irq_gen
    import mphy_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_chunks,
    input  logic [CNT_W-1:0] tx_credits,
    input  logic [NERR-1:0]  err_strb,
    input  logic             rst_done,
    input  logic             ftr_valid,
    input  logic [CNT_W-1:0] ftr_rx_cnt,
    input  logic [CNT_W-1:0] ftr_tx_cnt,
    input  logic             hdr_strb,
    input  logic             mask_we,
    input  logic [NERR-1:0]  mask_wdata,
    input  logic             clr_we,
    input  logic [STS_W-1:0] clr_data,
    output logic             irq_n,
    output logic [STS_W-1:0] status,
    output logic             exst
);
    logic [STS_W-1:0] sts_w;
    logic             exst_w;
    logic [NSRC-1:0]  src_avail;
    logic [NSRC-1:0]  src_zero;
    logic [NSRC-1:0]  src_pend;
    logic             irq_q;

    mphy_sts_reg u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_strb   (err_strb),
        .rst_done   (rst_done),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .clr_we     (clr_we),
        .clr_data   (clr_data),
        .sts        (sts_w),
        .exst       (exst_w)
    );

    assign src_avail = {exst_w, (tx_credits != '0), (rx_chunks != '0)};
    assign src_zero  = {!exst_w, (ftr_tx_cnt == '0), (ftr_rx_cnt == '0)};

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            mphy_avail_fsm u_fsm (
                .clk       (clk),
                .rst_n     (rst_n),
                .avail     (src_avail[s]),
                .ftr_valid (ftr_valid),
                .ftr_zero  (src_zero[s]),
                .hdr_strb  (hdr_strb),
                .pend      (src_pend[s])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b1;
        else        irq_q <= !((|src_pend) || sts_w[RSTC_B]);
    end

    assign irq_n  = irq_q;
    assign status = sts_w;
    assign exst   = exst_w;

    // R8: reset-complete keeps the line low in the following cycle
    a_r8_rstc_holds_line: assert property (@(posedge clk) disable iff (!rst_n)
        sts_w[RSTC_B] |=> !irq_n);
    // R4: with nothing pending and no reset-complete, the line is released
    a_r4_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (src_pend == '0 && !sts_w[RSTC_B]) |=> irq_n);
endmodule

// File: tb/mphy_irq_gen_tb_top.sv
module mphy_irq_gen_tb_top;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] rx_chunks = '0, tx_credits = '0, ftr_rx_cnt = '0, ftr_tx_cnt = '0;
    logic [3:0]    err_strb = '0, mask_wdata = '0;
    logic          rst_done = 0, ftr_valid = 0, hdr_strb = 0, mask_we = 0, clr_we = 0;
    logic [4:0]    clr_data = '0;
    logic          irq_n, exst;
    logic [4:0]    status;

    mphy_irq_gen #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_chunks(rx_chunks), .tx_credits(tx_credits),
        .err_strb(err_strb), .rst_done(rst_done), .ftr_valid(ftr_valid),
        .ftr_rx_cnt(ftr_rx_cnt), .ftr_tx_cnt(ftr_tx_cnt), .hdr_strb(hdr_strb),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .clr_we(clr_we),
        .clr_data(clr_data), .irq_n(irq_n), .status(status), .exst(exst)
    );

    always #4 clk = ~clk;

    typedef struct {
        int         due;
        logic       irq;
        logic [4:0] sts;
        logic       ex;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare the head item in the cycle it is due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (e.due < cyc) begin
                n_bad++;
                $display("FAIL %s: check missed, due %0d seen %0d", e.tag, e.due, cyc);
            end else if (irq_n !== e.irq || status !== e.sts || exst !== e.ex) begin
                n_bad++;
                $display("FAIL %s: actual irq_n=%b status=%b exst=%b expected irq_n=%b status=%b exst=%b",
                         e.tag, irq_n, status, exst, e.irq, e.sts, e.ex);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_at(int d, logic i, logic [4:0] s, logic x, string tag);
        exp_t e;
        e.due = cyc + d; e.irq = i; e.sts = s; e.ex = x; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic drain();
        while (q.size() > 0) tick();
    endtask

    task automatic footer(logic [CW-1:0] r, logic [CW-1:0] t);
        ftr_valid = 1; ftr_rx_cnt = r; ftr_tx_cnt = t;
        tick();
        ftr_valid = 0;
    endtask

    task automatic header(int d, logic i, logic [4:0] s, logic x, string tag);
        hdr_strb = 1;
        expect_at(d, i, s, x, tag);
        tick();
        hdr_strb = 0;
        drain();
    endtask

    task automatic clear(logic [4:0] m);
        clr_we = 1; clr_data = m;
        tick();
        clr_we = 0; clr_data = '0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        expect_at(1, 1, 5'b0, 0, "R1 reset state");
        drain();

        // R2: armed from reset, receive chunks appear
        rx_chunks = 3;
        expect_at(1, 1, 5'b0, 0, "R2 not early");
        expect_at(2, 0, 5'b0, 0, "R2 rx fires");
        drain();
        // R4: header releases, no re-fire
        header(2, 1, 5'b0, 0, "R4 release rx");
        expect_at(3, 1, 5'b0, 0, "R4 no refire");
        drain();

        // R2 negative: footer reported non-zero
        footer(3, 0);
        rx_chunks = 0; tick();
        rx_chunks = 5;
        expect_at(3, 1, 5'b0, 0, "R2 no fire after nonzero footer");
        drain();
        rx_chunks = 0; tick();
        footer(0, 0);
        rx_chunks = 2;
        expect_at(1, 1, 5'b0, 0, "R2 not early");
        expect_at(2, 0, 5'b0, 0, "R2 rx fires after zero footer");
        drain();
        header(2, 1, 5'b0, 0, "R4 release rx");

        // R3: credits
        tx_credits = 4;
        expect_at(2, 0, 5'b0, 0, "R3 tx fires");
        drain();
        header(2, 1, 5'b0, 0, "R4 release tx");
        footer(2, 4);
        tx_credits = 0; tick();
        tx_credits = 6;
        expect_at(3, 1, 5'b0, 0, "R3 no fire after nonzero footer");
        drain();
        tx_credits = 0; tick();
        footer(2, 0);

        // R5 / R10: masked error
        err_strb = 4'b0010;
        expect_at(1, 1, 5'b00010, 0, "R5 bit1 sticky set");
        expect_at(3, 1, 5'b00010, 0, "R10 masked no irq");
        tick(); err_strb = '0;
        drain();

        // R6 / R7: unmask bit1
        mask_we = 1; mask_wdata = 4'b1101;
        expect_at(1, 1, 5'b00010, 1, "R6 exst after unmask");
        expect_at(2, 1, 5'b00010, 1, "R7 not early");
        expect_at(3, 0, 5'b00010, 1, "R7 exst irq");
        tick(); mask_we = 0;
        drain();
        header(2, 1, 5'b00010, 1, "R4 release exst");

        // R9: clearing with zero leaves bit, with one clears
        expect_at(1, 1, 5'b00010, 1, "R9 zero write keeps");
        clear(5'b00001);
        drain();
        expect_at(1, 1, 5'b00000, 0, "R9 one write clears");
        clear(5'b00010);
        drain();

        // R7: re-arm by footer with exst=0, then error from strobe
        footer(2, 0);
        err_strb = 4'b0010;
        expect_at(1, 1, 5'b00010, 1, "R5 set again");
        expect_at(2, 1, 5'b00010, 1, "R7 not early");
        expect_at(3, 0, 5'b00010, 1, "R7 irq 3 cycles after strobe");
        tick(); err_strb = '0;
        drain();
        header(2, 1, 5'b00010, 1, "R4 release exst");
        expect_at(1, 1, 5'b0, 0, "R9 clear");
        clear(5'b00010);
        drain();

        // R9: set wins over same-cycle clear; R10 bit3 still masked
        err_strb = 4'b1000; clr_we = 1; clr_data = 5'b01000;
        expect_at(1, 1, 5'b01000, 0, "R9 set wins");
        tick(); err_strb = '0; clr_we = 0; clr_data = '0;
        drain();
        expect_at(1, 1, 5'b0, 0, "R9 clear bit3");
        clear(5'b01000);
        drain();

        // R8: reset complete holds the line
        rst_done = 1;
        expect_at(1, 1, 5'b10000, 1, "R8 rstc set");
        expect_at(2, 0, 5'b10000, 1, "R8 irq low");
        tick(); rst_done = 0;
        drain();
        header(2, 0, 5'b10000, 1, "R8 header ignored");
        expect_at(1, 0, 5'b00000, 0, "R8 line low one more cycle");
        expect_at(2, 1, 5'b00000, 0, "R8 released after clear");
        clear(5'b10000);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule